// File: doc/BRIEF.md
# Windowed Bank-Register Memory Mapper

This block sits between a processor with a 16-bit address bus and a 512 KB static RAM. The processor's address space is cut into eight 8 KB windows. Each window owns a 6-bit bank register, and the top three address bits choose which register drives the upper physical address lines. Any window can therefore be pointed at any of 64 physical 8 KB banks, independently of the other seven.

Software loads a bank register through a small register window, which is selected by a strobe from the system decoder. The low three address bits pick the register. On a read through the same window, the register's current value comes back on the data bus. The block also produces the RAM output-enable and write-enable strobes from the processor read/write line, qualified by the second clock phase. Decode of ROM and I/O stays outside the block. The block only sees a RAM-select input. When that input is low, the address passes through untranslated and no RAM strobe is driven.

All state is clocked by a fast system clock. The second clock phase is a level input, and the block detects its falling edge on that clock.

Top module: `bank_mmu`

## Requirements
- R1: After reset, bank register n holds the value n. A RAM access to any address A then yields the physical address A zero-extended to 19 bits, so the lowest 64 KB appears identity-mapped.
- R2: While `ram_sel` is high, `sram_addr[18:13]` equals the bank register indexed by `cpu_addr[15:13]`, and `sram_addr[12:0]` equals `cpu_addr[12:0]`. This is combinational in the same cycle.
- R3: While `ram_sel` is low, `sram_addr` equals `{3'b000, cpu_addr}` whatever the bank registers hold.
- R4: `sram_oe_n` is low exactly when `ram_sel`, `cpu_rw` (1 = read) and `phi2` are all high.
- R5: `sram_we_n` is low exactly when `ram_sel` and `phi2` are high and `cpu_rw` is low.
- R6: A register write occurs in a system-clock cycle that has `phi2`=1, `reg_sel`=1 and `cpu_rw`=0, and that is followed by a cycle with `phi2`=0. The values sampled in the first cycle count. Register `cpu_addr[2:0]` then takes `cpu_wdata[5:0]` at the clock edge that ends the second cycle.
- R7: A register write changes only the register it indexes. All other registers keep their values.
- R8: While `reg_sel` and `cpu_rw` are both high, `cpu_rdata` equals `{2'b00, register[cpu_addr[2:0]]}`. Otherwise `cpu_rdata` is zero.
- R9: The following have no effect on any register: `cpu_wdata[7:6]`, a register-window read, and a register-window write while `phi2` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the processor phase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phi2 | input | 1 | Processor second clock phase, level |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | Processor read/write, 1 = read |
| ram_sel | input | 1 | External decode: access targets RAM |
| reg_sel | input | 1 | External decode: access targets the bank-register window |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Register readback, zero when not reading the window |
| sram_addr | output | 19 | Physical RAM address |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |

## Verification
A behavioural model holds the eight bank values in an array. It is compared with every output on every clock. The bench first sweeps all combinations of select, direction and phase, which isolates the strobe terms from one another. Directed writes with the top data bits set, writes where the phase does not fall, and window reads show whether a commit happens only on the phase fall, and only into the indexed register. RAM accesses at window edges, such as offset 0x1FFF and window seven, separate a correct bank splice from an off-by-one slice. A long pseudo-random stretch then mixes overlapping selects and phase patterns, to expose timing slips in the edge detection.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  localparam int unsigned MMU_WIN_BITS  = 3;
  localparam int unsigned MMU_BANK_BITS = 6;
  localparam int unsigned MMU_OFF_BITS  = 13;
  localparam int unsigned MMU_DATA_W    = 8;

  // Control bits captured while the phase clock is high
  typedef struct packed {
    logic phase;
    logic rd;
    logic sel;
  } ctl_smp_t;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic sel, input logic rd, input logic phase);
    acc_kind_t k;
    k = ACC_IDLE;
    if (sel && phase) begin
      k = rd ? ACC_READ : ACC_WRITE;
    end
    return k;
  endfunction

endpackage

// File: rtl/mmu_bank_regs.sv
module mmu_bank_regs
  import mmu_pkg::*;
#(
  parameter int unsigned WIN_BITS  = MMU_WIN_BITS,
  parameter int unsigned BANK_BITS = MMU_BANK_BITS,
  parameter int unsigned DATA_W    = MMU_DATA_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            phi2,
  input  logic                            cpu_rw,
  input  logic                            reg_sel,
  input  logic [WIN_BITS-1:0]             idx,
  input  logic [DATA_W-1:0]               wdata,
  output logic [(2**WIN_BITS)*BANK_BITS-1:0] bank_flat,
  output logic                            commit
);

  localparam int unsigned NUM_WIN = 2 ** WIN_BITS;

  ctl_smp_t              ctl_q, ctl_d;
  logic [WIN_BITS-1:0]   idx_q, idx_d;
  logic [BANK_BITS-1:0]  data_q, data_d;

  // Capture bus state every clock; used on the cycle the phase falls
  always_comb begin
    ctl_d.phase = phi2;
    ctl_d.rd    = cpu_rw;
    ctl_d.sel   = reg_sel;
    idx_d       = idx;
    data_d      = wdata[BANK_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  assign commit = ctl_q.phase & ~phi2 & ctl_q.sel & ~ctl_q.rd;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_bank
    logic                 en;
    logic [BANK_BITS-1:0] val_q;
    logic [BANK_BITS-1:0] val_d;

    always_comb begin
      en    = commit && (idx_q == WIN_BITS'(g));
      val_d = data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= BANK_BITS'(g);
      end else if (en) begin
        val_q <= val_d;
      end
    end

    assign bank_flat[g*BANK_BITS +: BANK_BITS] = val_q;
  end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter int unsigned WIN_BITS  = 3,
  parameter int unsigned BANK_BITS = 6,
  parameter int unsigned OFF_BITS  = 13,
  parameter int unsigned DATA_W    = 8
) (
  input  logic [(2**WIN_BITS)*BANK_BITS-1:0] bank_flat,
  input  logic [WIN_BITS+OFF_BITS-1:0]       cpu_addr,
  input  logic                               ram_sel,
  input  logic                               reg_sel,
  input  logic                               cpu_rw,
  output logic [BANK_BITS+OFF_BITS-1:0]      sram_addr,
  output logic [DATA_W-1:0]                  cpu_rdata
);

  localparam int unsigned CPU_AW = WIN_BITS + OFF_BITS;
  localparam int unsigned PA_W   = BANK_BITS + OFF_BITS;

  logic [WIN_BITS-1:0]  win;
  logic [WIN_BITS-1:0]  ridx;
  logic [BANK_BITS-1:0] win_bank;
  logic [BANK_BITS-1:0] rd_bank;

  always_comb begin
    win      = cpu_addr[CPU_AW-1 -: WIN_BITS];
    ridx     = cpu_addr[WIN_BITS-1:0];
    win_bank = bank_flat[win*BANK_BITS +: BANK_BITS];
    rd_bank  = bank_flat[ridx*BANK_BITS +: BANK_BITS];
  end

  always_comb begin
    if (ram_sel) begin
      sram_addr = {win_bank, cpu_addr[OFF_BITS-1:0]};
    end else begin
      sram_addr = PA_W'(cpu_addr);
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (reg_sel && cpu_rw) begin
      cpu_rdata = DATA_W'(rd_bank);
    end
  end

endmodule

// File: rtl/mmu_strobe.sv
module mmu_strobe
  import mmu_pkg::*;
(
  input  logic ram_sel,
  input  logic cpu_rw,
  input  logic phi2,
  output logic sram_oe_n,
  output logic sram_we_n
);

  acc_kind_t kind;

  always_comb begin
    kind      = classify(ram_sel, cpu_rw, phi2);
    sram_oe_n = (kind != ACC_READ);
    sram_we_n = (kind != ACC_WRITE);
  end

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import mmu_pkg::*;
#(
  parameter int unsigned WIN_BITS  = MMU_WIN_BITS,
  parameter int unsigned BANK_BITS = MMU_BANK_BITS,
  parameter int unsigned OFF_BITS  = MMU_OFF_BITS,
  parameter int unsigned DATA_W    = MMU_DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          phi2,
  input  logic [WIN_BITS+OFF_BITS-1:0]  cpu_addr,
  input  logic                          cpu_rw,
  input  logic                          ram_sel,
  input  logic                          reg_sel,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic [BANK_BITS+OFF_BITS-1:0] sram_addr,
  output logic                          sram_oe_n,
  output logic                          sram_we_n
);

  localparam int unsigned NUM_WIN = 2 ** WIN_BITS;
  localparam int unsigned FLAT_W  = NUM_WIN * BANK_BITS;

  logic [FLAT_W-1:0] bank_flat;
  logic              wr_commit;

  mmu_bank_regs #(
    .WIN_BITS (WIN_BITS),
    .BANK_BITS(BANK_BITS),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi2     (phi2),
    .cpu_rw   (cpu_rw),
    .reg_sel  (reg_sel),
    .idx      (cpu_addr[WIN_BITS-1:0]),
    .wdata    (cpu_wdata),
    .bank_flat(bank_flat),
    .commit   (wr_commit)
  );

  mmu_xlate #(
    .WIN_BITS (WIN_BITS),
    .BANK_BITS(BANK_BITS),
    .OFF_BITS (OFF_BITS),
    .DATA_W   (DATA_W)
  ) u_xlate (
    .bank_flat(bank_flat),
    .cpu_addr (cpu_addr),
    .ram_sel  (ram_sel),
    .reg_sel  (reg_sel),
    .cpu_rw   (cpu_rw),
    .sram_addr(sram_addr),
    .cpu_rdata(cpu_rdata)
  );

  mmu_strobe u_strobe (
    .ram_sel  (ram_sel),
    .cpu_rw   (cpu_rw),
    .phi2     (phi2),
    .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n)
  );

endmodule

// File: rtl/bank_mmu_chk.sv
module bank_mmu_chk #(
  parameter int unsigned WIN_BITS  = 3,
  parameter int unsigned BANK_BITS = 6,
  parameter int unsigned OFF_BITS  = 13
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 phi2,
  input logic [WIN_BITS+OFF_BITS-1:0]         cpu_addr,
  input logic                                 cpu_rw,
  input logic                                 ram_sel,
  input logic [BANK_BITS+OFF_BITS-1:0]        sram_addr,
  input logic                                 sram_oe_n,
  input logic                                 sram_we_n,
  input logic [(2**WIN_BITS)*BANK_BITS-1:0]   bank_flat,
  input logic                                 wr_commit
);

  localparam int unsigned PA_W = BANK_BITS + OFF_BITS;

  AST_ROM_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> (sram_addr == PA_W'(cpu_addr))); // R3

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (sram_addr[OFF_BITS-1:0] == cpu_addr[OFF_BITS-1:0])); // R2

  AST_NO_STROBE_OFF_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> (sram_oe_n && sram_we_n)); // R4

  AST_OE_READ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (cpu_rw && phi2)); // R4

  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !cpu_rw && phi2)); // R5

  AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !phi2); // R6

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(bank_flat)); // R7

endmodule

bind bank_mmu bank_mmu_chk #(
  .WIN_BITS (WIN_BITS),
  .BANK_BITS(BANK_BITS),
  .OFF_BITS (OFF_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phi2     (phi2),
  .cpu_addr (cpu_addr),
  .cpu_rw   (cpu_rw),
  .ram_sel  (ram_sel),
  .sram_addr(sram_addr),
  .sram_oe_n(sram_oe_n),
  .sram_we_n(sram_we_n),
  .bank_flat(bank_flat),
  .wr_commit(wr_commit)
);

// File: tb/bank_mmu_bench.sv
module bank_mmu_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        phi2;
  logic [15:0] cpu_addr;
  logic        cpu_rw;
  logic        ram_sel;
  logic        reg_sel;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic [18:0] sram_addr;
  logic        sram_oe_n;
  logic        sram_we_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // behavioural model state
  logic [5:0]  ref_bank [8];
  logic        s_phi, s_rw, s_sel;
  logic [2:0]  s_idx;
  logic [5:0]  s_dat;

  bank_mmu u_bank_mmu (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi2     (phi2),
    .cpu_addr (cpu_addr),
    .cpu_rw   (cpu_rw),
    .ram_sel  (ram_sel),
    .reg_sel  (reg_sel),
    .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .sram_addr(sram_addr),
    .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update: commit on phase fall using previous-cycle sample
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) ref_bank[i] = 6'(i);
      s_phi = 0; s_rw = 0; s_sel = 0; s_idx = 0; s_dat = 0;
    end else begin
      if (s_phi && !phi2 && s_sel && !s_rw) ref_bank[s_idx] = s_dat;
      s_phi = phi2; s_rw = cpu_rw; s_sel = reg_sel;
      s_idx = cpu_addr[2:0]; s_dat = cpu_wdata[5:0];
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [18:0] e_addr;
      logic [7:0]  e_rd;
      e_addr = ram_sel ? {ref_bank[cpu_addr[15:13]], cpu_addr[12:0]} : {3'b000, cpu_addr};
      e_rd   = (reg_sel && cpu_rw) ? {2'b00, ref_bank[cpu_addr[2:0]]} : 8'h00;
      chk(ram_sel ? "R2 sram_addr" : "R3 sram_addr", 32'(sram_addr), 32'(e_addr));
      chk("R4 sram_oe_n", 32'(sram_oe_n), 32'(!(ram_sel && cpu_rw && phi2)));
      chk("R5 sram_we_n", 32'(sram_we_n), 32'(!(ram_sel && !cpu_rw && phi2)));
      chk("R8 cpu_rdata", 32'(cpu_rdata), 32'(e_rd));
    end
  end

  task automatic drive(input logic [15:0] a, input logic rw, input logic ph,
                       input logic rs, input logic gs, input logic [7:0] d);
    @(posedge clk);
    #1;
    cpu_addr = a; cpu_rw = rw; phi2 = ph; ram_sel = rs; reg_sel = gs; cpu_wdata = d;
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [7:0] d);
    drive({13'h0, idx}, 1'b0, 1'b1, 1'b0, 1'b1, d);
    drive({13'h0, idx}, 1'b0, 1'b0, 1'b0, 1'b1, d);
  endtask

  task automatic reg_read_check(input logic [2:0] idx, input logic [5:0] exp, input string tag);
    drive({13'h0, idx}, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    @(negedge clk);
    chk(tag, 32'(cpu_rdata), 32'({2'b00, exp}));
  endtask

  task automatic ram_check(input logic [15:0] a, input logic [18:0] exp, input string tag);
    drive(a, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    chk(tag, 32'(sram_addr), 32'(exp));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; phi2 = 0; cpu_addr = 0; cpu_rw = 1; ram_sel = 0; reg_sel = 0; cpu_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 reset oe_n", 32'(sram_oe_n), 32'd1);
    chk("R5 reset we_n", 32'(sram_we_n), 32'd1);
    @(posedge clk); #1; rst_n = 1;

    // R1: reset values and identity map
    for (int i = 0; i < 8; i++) reg_read_check(3'(i), 6'(i), "R1 reset bank value");
    ram_check(16'h6123, 19'h06123, "R1 identity map");
    ram_check(16'hFFFF, 19'h0FFFF, "R1 identity map top");

    // R4/R5: sweep select, direction and phase
    for (int c = 0; c < 8; c++) drive(16'h2345, c[1], c[2], c[0], 1'b0, 8'h55);

    // R6/R9: write with top data bits set
    reg_write(3'd3, 8'hEA);
    reg_read_check(3'd3, 6'h2A, "R6 R9 written value");
    // R7: neighbours untouched
    reg_read_check(3'd2, 6'd2, "R7 neighbour 2");
    reg_read_check(3'd4, 6'd4, "R7 neighbour 4");
    // R2: window boundary with remapped bank
    ram_check(16'h7FFF, 19'h55FFF, "R2 window 3 top offset");
    ram_check(16'h6000, 19'h54000, "R2 window 3 base");
    // R3: non-RAM ignores the mapping
    drive(16'h7ABC, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk("R3 passthrough", 32'(sram_addr), 32'h07ABC);

    // R9: read through window with phase fall: no change
    drive(16'h0003, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    drive(16'h0003, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11);
    reg_read_check(3'd3, 6'h2A, "R9 read no effect");
    // R9: write held while phase stays high: no commit
    drive(16'h0005, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
    drive(16'h0005, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
    drive(16'h0005, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    @(negedge clk);
    chk("R9 no commit without fall", 32'(cpu_rdata), 32'h05);

    // R2: last window, all-ones bank
    reg_write(3'd7, 8'h3F);
    ram_check(16'hFFFF, 19'h7FFFF, "R2 window 7 max");
    reg_write(3'd0, 8'h00);
    reg_read_check(3'd0, 6'h00, "R6 bank zero");
    reg_read_check(3'd7, 6'h3F, "R7 window 7 kept");

    // pseudo-random mix, compared every cycle with the model
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[15:0], r[16], r[17], r[18], r[19], r[27:20]);
    end
    drive(16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule